// File: doc/BRIEF.md
# Accumulator ALU Datapath

This block is a narrow datapath built around one accumulator register and a small ALU. The ALU takes the accumulator as its first operand and a value from a shared data bus as its second. Three mode controls choose the ALU function:

- an A-gate that either passes the accumulator or forces that input to zero;
- an operand-invert bit;
- a logic/arithmetic select.

A single adder provides pass, add, subtract and negate. In arithmetic mode the inverted operand goes into the adder and the invert bit also serves as the carry-in.

A load enable writes the ALU result into the accumulator on a rising clock edge. A separate drive enable places the accumulator on the bus side, so that a surrounding controller can store it to memory. Instruction sequencing and memory are handled outside this block.

Top module: `acc_alu_datapath`

## Requirements
- R1: When `rst` is high at a rising clock edge, `acc_q` becomes 0 after that edge, whatever the other inputs are.
- R2: When `load` is 0 at a rising edge, `acc_q` keeps its value across that edge.
- R3: Arithmetic mode (`logic_sel`=0) with `a_gate`=0 and `inv_b`=0 loads the bus operand unchanged into the accumulator.
- R4: Arithmetic mode with `a_gate`=1 and `inv_b`=0 loads `acc_q + bus_in`, modulo 2^W, with the carry discarded (for example, 15 + 1 gives 0).
- R5: Arithmetic mode with `a_gate`=1 and `inv_b`=1 loads `acc_q - bus_in`, modulo 2^W.
- R6: Arithmetic mode with `a_gate`=0 and `inv_b`=1 loads the two's-complement negation of `bus_in`.
- R7: Logic mode (`logic_sel`=1) with `a_gate`=1 and `inv_b`=0 loads `acc_q | bus_in`.
- R8: Logic mode with `a_gate`=0 and `inv_b`=0 loads `acc_q ^ bus_in`.
- R9: Logic mode with `a_gate`=0 and `inv_b`=1 loads `~bus_in`.
- R10: Logic mode with `a_gate`=1 and `inv_b`=1 loads `acc_q | ~bus_in`.
- R11: `bus_oe` equals `acc_drive`. While `acc_drive` is 1, `bus_out` equals `acc_q`. While `acc_drive` is 0, `bus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | W | Operand taken from the data bus |
| a_gate | input | 1 | 1 passes the accumulator into the ALU, 0 forces zero; in logic mode it selects OR (1) or XOR/NOT (0) |
| inv_b | input | 1 | Inverts the operand; also acts as the adder carry-in |
| logic_sel | input | 1 | 1 selects logic mode, 0 selects arithmetic mode |
| load | input | 1 | Captures the ALU result into the accumulator |
| acc_drive | input | 1 | Requests the accumulator onto the bus |
| acc_q | output | W | Accumulator value |
| bus_out | output | W | Value driven toward the bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
Subtract and OR-with-inverted-operand results only show their edge cases when the accumulator already holds particular values before the operation. Examples are a borrow below zero, or all ones meeting an all-zero operand. These states can only be built from the ports through a chain of earlier loads. The stimulus therefore runs long random chains of mode, operand and load choices. Each step compares against a bench model that carries the accumulator forward. Directed sequences first set up the wrap cases, such as 15 + 1 and 0 - 1, before the random phase.

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic         a_gate,
  input  logic         inv_b,
  input  logic         logic_sel,
  input  logic         load,
  input  logic         acc_drive,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] a_eff, b_eff, sum, logic_res, result;

  assign a_eff = a_gate ? acc_q : ZERO;
  assign b_eff = inv_b ? ~bus_in : bus_in;
  assign sum   = a_eff + b_eff + {{(W-1){1'b0}}, inv_b};

  // OR when the A-gate is set; otherwise XOR with the accumulator, or plain NOT when inverting
  assign logic_res = a_gate ? (acc_q | b_eff) : (inv_b ? b_eff : (acc_q ^ bus_in));
  assign result    = logic_sel ? logic_res : sum;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= ZERO;
    else if (load) acc_q <= result;
  end

  assign bus_oe  = acc_drive;
  assign bus_out = acc_drive ? acc_q : ZERO;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> acc_q == ZERO);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(acc_q));

  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !logic_sel && !a_gate && !inv_b) |=> acc_q == $past(bus_in));

  assert_add_R4: assert property (@(posedge clk) disable iff (rst)
    (load && !logic_sel && a_gate && !inv_b) |=> (acc_q - $past(acc_q)) == $past(bus_in));

  assert_sub_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !logic_sel && a_gate && inv_b) |=> ($past(acc_q) - acc_q) == $past(bus_in));

  assert_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !logic_sel && !a_gate && inv_b) |=> (acc_q + $past(bus_in)) == ZERO);

  assert_not_R9: assert property (@(posedge clk) disable iff (rst)
    (load && logic_sel && !a_gate && inv_b) |=> (acc_q ^ $past(bus_in)) == ~ZERO);

  assert_drive_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_drive |-> (bus_out == ZERO && !bus_oe));

endmodule

// File: tb/tb_acc_alu_datapath.sv
module tb_acc_alu_datapath;
  localparam int W = 4;

  logic clk = 0;
  logic rst, a_gate, inv_b, logic_sel, load, acc_drive;
  logic [W-1:0] bus_in, acc_q, bus_out;
  logic bus_oe;
  logic [W-1:0] exp_acc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  acc_alu_datapath #(.W(W)) dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .a_gate(a_gate), .inv_b(inv_b),
    .logic_sel(logic_sel), .load(load), .acc_drive(acc_drive),
    .acc_q(acc_q), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] acc, logic [W-1:0] op,
                                         logic ag, logic iv, logic lg);
    if (!lg) begin
      if (!ag && !iv) return op;            // R3
      if (ag && !iv)  return acc + op;      // R4
      if (ag && iv)   return acc - op;      // R5
      return -op;                           // R6
    end
    if (ag && !iv) return acc | op;         // R7
    if (!ag && !iv) return acc ^ op;        // R8
    if (!ag && iv)  return ~op;             // R9
    return acc | ~op;                       // R10
  endfunction

  function automatic string req_of(logic ld, logic ag, logic iv, logic lg);
    if (!ld) return "R2";
    case ({lg, ag, iv})
      3'b000: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b001: return "R6";
      3'b110: return "R7";
      3'b100: return "R8";
      3'b101: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] op, logic ag, logic iv, logic lg, logic ld, logic drv);
    @(negedge clk);
    bus_in = op; a_gate = ag; inv_b = iv; logic_sel = lg; load = ld; acc_drive = drv;
    @(posedge clk);
    if (ld) exp_acc = model(exp_acc, op, ag, iv, lg);
    #1;
    check(req_of(ld, ag, iv, lg), acc_q, exp_acc);
    check("R11", bus_out, drv ? exp_acc : '0);
    check("R11", {3'b0, bus_oe}, {3'b0, drv});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; bus_in = 4'hA; a_gate = 1; inv_b = 0; logic_sel = 0; load = 1; acc_drive = 0;
    exp_acc = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1", acc_q, 4'd0);
    @(negedge clk); rst = 0;

    step(4'd1, 0, 0, 0, 1, 0);   // R3 load 1
    step(4'd2, 1, 0, 0, 1, 0);   // R4 1+2=3
    check("R4", acc_q, 4'd3);
    step(4'd9, 1, 0, 0, 0, 1);   // R2 hold, R11 drive
    step(4'd12, 1, 0, 0, 1, 0);  // R4 3+12=15
    step(4'd1, 1, 0, 0, 1, 0);   // R4 wrap to 0
    check("R4", acc_q, 4'd0);
    step(4'd1, 1, 1, 0, 1, 1);   // R5 0-1=15
    check("R5", acc_q, 4'd15);
    step(4'd5, 0, 1, 0, 1, 0);   // R6 -5=11
    check("R6", acc_q, 4'd11);
    step(4'd1, 0, 0, 0, 1, 0);   // R3
    step(4'b1001, 1, 0, 1, 1, 0);// R7 0001|1001
    check("R7", acc_q, 4'b1001);
    step(4'b0011, 0, 0, 1, 1, 0);// R8
    step(4'b0110, 0, 1, 1, 1, 0);// R9
    step(4'b1111, 1, 1, 1, 1, 1);// R10
    step(4'd0, 0, 1, 0, 0, 1);   // R2 negate ignored
    step(4'd7, 1, 1, 1, 0, 0);   // R2 logic ignored

    for (int i = 0; i < 400; i++) begin
      step(W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 3) != 0), 1'($urandom));
    end

    @(negedge clk); rst = 1; load = 1; a_gate = 0; inv_b = 0; logic_sel = 0; bus_in = 4'd6;
    @(posedge clk); #1; exp_acc = '0;
    check("R1", acc_q, 4'd0);
    @(negedge clk); rst = 0;
    step(4'd8, 0, 0, 0, 1, 1);
    check("R3", acc_q, 4'd8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule